// File: doc/BRIEF.md
# Source Address Ingress/Egress Guard

This block screens the source IPv4 address of every packet header that a decoder hands it. Inbound packets must carry a source that falls inside one of the prefixes assigned to the port they arrived on. Outbound packets must carry a source that belongs to the internal networks, which are all prefixes programmed on any port. Sources inside a reserved special-purpose block are rejected in both directions. Each header gets a one-bit drop flag one cycle after it is presented.

The block also produces the final verdict for each packet. A separate hop-count filter delivers its own per-packet verdicts in the same packet order, possibly earlier or later than this block's flags. Both verdict streams are queued in small FIFOs. A forward-or-drop decision is issued only when both verdicts for the next packet are present. The decision is drop when either filter asks for it.

The prefix tables are programmed through a one-cycle write port. Each write carries a table select, a port, a slot, an enable bit, a base address and a mask. Each port has its own bank of allowed-prefix slots. A single reserved bank is preloaded at reset with the common non-routable blocks.

Top module: `src_addr_guard`

## Requirements
- R1: An inbound header (hdr_egress=0) whose port has at least one enabled allowed prefix is flagged for drop when its source matches none of them, and passes when it matches one (match means (src & mask) == (base & mask)).
- R2: An inbound header on a port with no enabled allowed-prefix slot passes unless its source is in an enabled reserved block.
- R3: A source matching any enabled reserved entry (cfg_rsv=1 table) is flagged for drop in both directions. After reset the reserved slots 0..7 hold 0.0.0.0/8, 10.0.0.0/8, 127.0.0.0/8, 169.254.0.0/16, 172.16.0.0/12, 192.168.0.0/16, 224.0.0.0/4 and 240.0.0.0/4, and slots 8..15 are disabled. A reserved entry that is rewritten with cfg_on=0 no longer blocks.
- R4: An outbound header (hdr_egress=1) is flagged for drop when at least one allowed prefix is enabled on any port and its source matches none of them. It passes when it matches one of them.
- R5: af_valid is high for exactly the one cycle after the edge that samples hdr_valid, and af_drop carries that header's flag in the same cycle.
- R6: dec_drop is the OR of the address flag and the hop-count verdict of the same packet, paired in arrival order. No decision is issued until both verdicts of a packet have arrived.
- R7: A table write and a header lookup in the same cycle leave the lookup on the old table contents, and the new entry applies from the next header onward.
- R8: Writing an allowed-prefix slot with cfg_on=0 removes that prefix from both the inbound check of its port and the outbound internal set.
- R9: An allowed-prefix write (cfg_rsv=0) with cfg_slot at or above the per-port slot count (8) changes no entry.
- R10: After reset af_valid and dec_valid are low and all allowed-prefix slots are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header descriptor present this cycle |
| hdr_egress | input | 1 | 1 = outbound packet, 0 = inbound |
| hdr_port | input | PORT_W (2) | Port the packet arrived on |
| hdr_src | input | 32 | Source IPv4 address |
| cfg_we | input | 1 | Table write strobe |
| cfg_rsv | input | 1 | 1 = reserved table, 0 = allowed-prefix table of cfg_port |
| cfg_port | input | PORT_W (2) | Port whose allowed-prefix bank is written |
| cfg_slot | input | SLOT_W (4) | Slot index within the selected bank |
| cfg_on | input | 1 | Enable bit of the written entry |
| cfg_base | input | 32 | Prefix base address |
| cfg_mask | input | 32 | Prefix mask |
| hc_valid | input | 1 | Hop-count verdict present this cycle |
| hc_drop | input | 1 | Hop-count verdict, 1 = drop |
| af_valid | output | 1 | Address flag present |
| af_drop | output | 1 | Address flag, 1 = drop |
| dec_valid | output | 1 | Final decision present |
| dec_drop | output | 1 | Final decision, 1 = drop, 0 = forward |

## Verification
Two functions can meet in one cycle here: a table write and a lookup of a header that the written entry would change. The bench presents a header on an empty port in the same cycle as the write that gives that port its first prefix. It expects the flag of the old, empty table, and then expects the new prefix to decide the next header. The same bench also lets hop-count verdicts arrive before, with and after the address flags, and checks that each decision pairs the right packet's two verdicts.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef struct packed {
    logic        on;
    logic [31:0] base;
    logic [31:0] mask;
  } pfx_entry_t;

  // Power-up contents of the reserved bank
  function automatic pfx_entry_t rsv_default(input int idx);
    case (idx)
      0:       return '{1'b1, 32'h0000_0000, 32'hFF00_0000};
      1:       return '{1'b1, 32'h0A00_0000, 32'hFF00_0000};
      2:       return '{1'b1, 32'h7F00_0000, 32'hFF00_0000};
      3:       return '{1'b1, 32'hA9FE_0000, 32'hFFFF_0000};
      4:       return '{1'b1, 32'hAC10_0000, 32'hFFF0_0000};
      5:       return '{1'b1, 32'hC0A8_0000, 32'hFFFF_0000};
      6:       return '{1'b1, 32'hE000_0000, 32'hF000_0000};
      7:       return '{1'b1, 32'hF000_0000, 32'hF000_0000};
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/sag_prefix_bank.sv
module sag_prefix_bank
  import sag_pkg::*;
#(
  parameter int N      = 8,
  parameter bit PRESET = 1'b0,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_on,
  input  logic [31:0]   wr_base,
  input  logic [31:0]   wr_mask,
  input  logic [31:0]   look_addr,
  output logic          hit,
  output logic          any_on
);

  pfx_entry_t tbl [N];
  logic [N-1:0] hit_vec;
  logic [N-1:0] on_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        tbl[i] <= PRESET ? rsv_default(i) : '0;
      end
    end else if (wr_en) begin
      tbl[wr_idx] <= '{on: wr_on, base: wr_base & wr_mask, mask: wr_mask};
    end
  end

  // All slots compared at once against the looked-up address
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign on_vec[g]  = tbl[g].on;
    assign hit_vec[g] = tbl[g].on && ((look_addr & tbl[g].mask) == tbl[g].base);
  end

  assign hit    = |hit_vec;
  assign any_on = |on_vec;

  // R8: a match is only possible from an enabled slot
  p_hit_needs_on_r8: assert property (@(posedge clk) disable iff (rst)
    hit |-> any_on);

endmodule

// File: rtl/sag_fifo.sv
module sag_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign dout  = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));

  // R6: verdict queues must never lose or invent entries
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (push && full) |-> pop);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/sag_merge.sv
module sag_merge #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic af_in_valid,
  input  logic af_in_drop,
  input  logic hc_in_valid,
  input  logic hc_in_drop,
  output logic dec_valid,
  output logic dec_drop
);

  logic [1:0] q_push, q_din, q_dout, q_empty, q_full;
  logic       take;

  assign q_push = {hc_in_valid, af_in_valid};
  assign q_din  = {hc_in_drop,  af_in_drop};
  assign take   = !q_empty[0] && !q_empty[1];

  // One verdict queue per filter; index 0 address, index 1 hop-count
  for (genvar k = 0; k < 2; k++) begin : g_q
    sag_fifo #(.DEPTH(DEPTH), .W(1)) u_q (
      .clk   (clk),
      .rst   (rst),
      .push  (q_push[k]),
      .din   (q_din[k +: 1]),
      .pop   (take),
      .dout  (q_dout[k +: 1]),
      .empty (q_empty[k]),
      .full  (q_full[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_drop  <= 1'b0;
    end else begin
      dec_valid <= take;
      dec_drop  <= take && (q_dout[0] || q_dout[1]);
    end
  end

  // R6: a decision needs a verdict waiting in both queues
  p_dec_needs_both_r6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ($past(!q_empty[0]) && $past(!q_empty[1])));
  // R6: a queued drop from either side cannot turn into a forward
  p_drop_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (take && (q_dout[0] || q_dout[1])) |=> dec_drop);

  logic unused_full;
  assign unused_full = |q_full;

endmodule

// File: rtl/src_addr_guard.sv
module src_addr_guard
  import sag_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int PFX_PER_PORT = 8,
  parameter int RSV_ENTRIES  = 16,
  parameter int FIFO_DEPTH   = 8,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int MAX_N  = (PFX_PER_PORT > RSV_ENTRIES) ? PFX_PER_PORT : RSV_ENTRIES,
  localparam int SLOT_W = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int PIW    = (PFX_PER_PORT > 1) ? $clog2(PFX_PER_PORT) : 1,
  localparam int RIW    = (RSV_ENTRIES > 1) ? $clog2(RSV_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic              hdr_egress,
  input  logic [PORT_W-1:0] hdr_port,
  input  logic [31:0]       hdr_src,
  input  logic              cfg_we,
  input  logic              cfg_rsv,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic              cfg_on,
  input  logic [31:0]       cfg_base,
  input  logic [31:0]       cfg_mask,
  input  logic              hc_valid,
  input  logic              hc_drop,
  output logic              af_valid,
  output logic              af_drop,
  output logic              dec_valid,
  output logic              dec_drop
);

  logic [NUM_PORTS-1:0] port_hit, port_on;
  logic rsv_hit, rsv_on;
  logic rsv_wr;
  logic pfx_slot_ok, rsv_slot_ok;
  logic own_hit, own_on, int_hit, int_on;
  logic drop_c;

  assign pfx_slot_ok = 32'(cfg_slot) < PFX_PER_PORT;
  assign rsv_slot_ok = 32'(cfg_slot) < RSV_ENTRIES;
  assign rsv_wr      = cfg_we && cfg_rsv && rsv_slot_ok;

  sag_prefix_bank #(.N(RSV_ENTRIES), .PRESET(1'b1)) u_rsv (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (rsv_wr),
    .wr_idx    (cfg_slot[RIW-1:0]),
    .wr_on     (cfg_on),
    .wr_base   (cfg_base),
    .wr_mask   (cfg_mask),
    .look_addr (hdr_src),
    .hit       (rsv_hit),
    .any_on    (rsv_on)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_here;
    assign wr_here = cfg_we && !cfg_rsv && pfx_slot_ok && (cfg_port == PORT_W'(p));
    sag_prefix_bank #(.N(PFX_PER_PORT), .PRESET(1'b0)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_here),
      .wr_idx    (cfg_slot[PIW-1:0]),
      .wr_on     (cfg_on),
      .wr_base   (cfg_base),
      .wr_mask   (cfg_mask),
      .look_addr (hdr_src),
      .hit       (port_hit[p]),
      .any_on    (port_on[p])
    );
  end

  // Inbound uses the arrival port's bank; outbound uses every bank
  assign own_hit = port_hit[hdr_port];
  assign own_on  = port_on[hdr_port];
  assign int_hit = |port_hit;
  assign int_on  = |port_on;

  always_comb begin
    if (hdr_egress) drop_c = rsv_hit || (int_on && !int_hit);
    else            drop_c = rsv_hit || (own_on && !own_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      af_valid <= 1'b0;
      af_drop  <= 1'b0;
    end else begin
      af_valid <= hdr_valid;
      af_drop  <= hdr_valid && drop_c;
    end
  end

  sag_merge #(.DEPTH(FIFO_DEPTH)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .af_in_valid (af_valid),
    .af_in_drop  (af_drop),
    .hc_in_valid (hc_valid),
    .hc_in_drop  (hc_drop),
    .dec_valid   (dec_valid),
    .dec_drop    (dec_drop)
  );

  // R5: one flag per header, one cycle later
  p_flag_follows_hdr_r5: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> af_valid);
  p_no_stray_flag_r5: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !af_valid);
  // R3: a reserved match always ends in a drop flag
  p_rsv_forces_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && rsv_hit) |=> af_drop);
  // R1: inbound source inside its own port's prefix, not reserved, passes
  p_own_prefix_passes_r1: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && !hdr_egress && own_hit && !rsv_hit) |=> !af_drop);
  // R4: outbound source outside every programmed prefix is dropped
  p_egress_outside_r4: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_egress && int_on && !int_hit) |=> af_drop);

  logic unused_rsv_on;
  assign unused_rsv_on = rsv_on;

endmodule

// File: tb/sim_src_addr_guard.sv
module sim_src_addr_guard;

  logic        clk = 1'b0;
  logic        rst;
  logic        hdr_valid, hdr_egress;
  logic [1:0]  hdr_port;
  logic [31:0] hdr_src;
  logic        cfg_we, cfg_rsv, cfg_on;
  logic [1:0]  cfg_port;
  logic [3:0]  cfg_slot;
  logic [31:0] cfg_base, cfg_mask;
  logic        hc_valid, hc_drop;
  logic        af_valid, af_drop, dec_valid, dec_drop;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  bit af_q [64];
  bit hc_q [64];
  int na = 0, nh = 0, nd = 0;

  always #4 clk = ~clk;

  src_addr_guard u0 (
    .clk(clk), .rst(rst),
    .hdr_valid(hdr_valid), .hdr_egress(hdr_egress), .hdr_port(hdr_port), .hdr_src(hdr_src),
    .cfg_we(cfg_we), .cfg_rsv(cfg_rsv), .cfg_port(cfg_port), .cfg_slot(cfg_slot),
    .cfg_on(cfg_on), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .hc_valid(hc_valid), .hc_drop(hc_drop),
    .af_valid(af_valid), .af_drop(af_drop), .dec_valid(dec_valid), .dec_drop(dec_drop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Decision monitor: pairs verdicts in arrival order (R6)
  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      if (nd < na && nd < nh) begin
        chk(dec_drop == (af_q[nd] | hc_q[nd]), "R6 decision", int'(dec_drop), int'(af_q[nd] | hc_q[nd]));
      end else begin
        chk(1'b0, "R6 decision without both verdicts", 1, 0);
      end
      nd++;
    end
  end

  task automatic send_hdr(input bit eg, input logic [1:0] port, input logic [31:0] src,
                          input bit with_hc, input bit hcd, input bit exp, input string req);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_egress = eg; hdr_port = port; hdr_src = src;
    hc_valid = with_hc; hc_drop = hcd;
    af_q[na] = exp; na++;
    if (with_hc) begin hc_q[nh] = hcd; nh++; end
    @(negedge clk);
    hdr_valid = 1'b0; hc_valid = 1'b0;
    chk(af_valid == 1'b1, {req, " flag valid"}, int'(af_valid), 1);
    chk(af_drop == exp, req, int'(af_drop), int'(exp));
  endtask

  task automatic send_hc(input bit hcd);
    @(negedge clk);
    hc_valid = 1'b1; hc_drop = hcd;
    hc_q[nh] = hcd; nh++;
    @(negedge clk);
    hc_valid = 1'b0;
  endtask

  task automatic cfg_write(input bit rsv, input logic [1:0] port, input logic [3:0] slot,
                           input bit on, input logic [31:0] base, input logic [31:0] mask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rsv = rsv; cfg_port = port; cfg_slot = slot;
    cfg_on = on; cfg_base = base; cfg_mask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // {req[3:0], hc, egress, port[1:0], src[31:0], expected flag}
  localparam int NV = 18;
  localparam logic [40:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b0, 2'd0, 32'hCB007107, 1'b0},  // R1 in own /24
    {4'd1, 1'b1, 1'b0, 2'd0, 32'hC6336409, 1'b1},  // R1 other port's prefix
    {4'd1, 1'b0, 1'b0, 2'd1, 32'hC63364C8, 1'b0},  // R1
    {4'd1, 1'b0, 1'b0, 2'd1, 32'hCB007107, 1'b1},  // R1
    {4'd2, 1'b0, 1'b0, 2'd2, 32'h08080808, 1'b0},  // R2 empty port
    {4'd2, 1'b1, 1'b0, 2'd2, 32'h08080808, 1'b0},  // R2 hop-count alone drops
    {4'd3, 1'b0, 1'b0, 2'd2, 32'h0A010203, 1'b1},  // R3 10/8
    {4'd3, 1'b0, 1'b0, 2'd0, 32'hC0A80101, 1'b1},  // R3 192.168/16
    {4'd3, 1'b0, 1'b0, 2'd2, 32'hE0000005, 1'b1},  // R3 224/4
    {4'd3, 1'b0, 1'b0, 2'd2, 32'hAC1FFFFF, 1'b1},  // R3 top of 172.16/12
    {4'd3, 1'b0, 1'b0, 2'd2, 32'hAC200001, 1'b0},  // R3 just above 172.16/12
    {4'd3, 1'b0, 1'b0, 2'd2, 32'hA9FE0909, 1'b1},  // R3 169.254/16
    {4'd3, 1'b0, 1'b0, 2'd2, 32'h7F000001, 1'b1},  // R3 127/8
    {4'd3, 1'b0, 1'b1, 2'd2, 32'h0A000001, 1'b1},  // R3 outbound reserved
    {4'd4, 1'b0, 1'b1, 2'd2, 32'hCB007132, 1'b0},  // R4 internal via port 0
    {4'd4, 1'b0, 1'b1, 2'd0, 32'h08080808, 1'b1},  // R4 not internal
    {4'd1, 1'b0, 1'b0, 2'd3, 32'h647FFFFF, 1'b0},  // R1 top of /10
    {4'd1, 1'b0, 1'b0, 2'd3, 32'h64800000, 1'b1}   // R1 just past /10
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    hdr_valid = 0; hdr_egress = 0; hdr_port = 0; hdr_src = 0;
    cfg_we = 0; cfg_rsv = 0; cfg_port = 0; cfg_slot = 0; cfg_on = 0; cfg_base = 0; cfg_mask = 0;
    hc_valid = 0; hc_drop = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: quiet outputs after reset
    chk(af_valid == 1'b0, "R10 af_valid", int'(af_valid), 0);
    chk(dec_valid == 1'b0, "R10 dec_valid", int'(dec_valid), 0);
    // R10: all ports empty, so a public source passes on port 0
    send_hdr(1'b0, 2'd0, 32'h08080808, 1'b1, 1'b0, 1'b0, "R10 empty tables");

    cfg_write(1'b0, 2'd0, 4'd0, 1'b1, 32'hCB007100, 32'hFFFFFF00);
    cfg_write(1'b0, 2'd1, 4'd3, 1'b1, 32'hC6336400, 32'hFFFFFF00);
    cfg_write(1'b0, 2'd3, 4'd0, 1'b1, 32'h64400000, 32'hFFC00000);

    for (int i = 0; i < NV; i++) begin
      send_hdr(VEC[i][35], VEC[i][34:33], VEC[i][32:1], 1'b1, VEC[i][36], VEC[i][0],
               $sformatf("R%0d vector %0d", VEC[i][40:37], i));
    end
    // R5: flag lasts one cycle only
    @(negedge clk);
    chk(af_valid == 1'b0, "R5 single-cycle flag", int'(af_valid), 0);

    // R7: write and lookup in the same cycle; lookup sees the empty port 2
    @(negedge clk);
    cfg_we = 1'b1; cfg_rsv = 1'b0; cfg_port = 2'd2; cfg_slot = 4'd0;
    cfg_on = 1'b1; cfg_base = 32'h08000000; cfg_mask = 32'hFF000000;
    hdr_valid = 1'b1; hdr_egress = 1'b0; hdr_port = 2'd2; hdr_src = 32'h09090909;
    hc_valid = 1'b1; hc_drop = 1'b0;
    af_q[na] = 1'b0; na++; hc_q[nh] = 1'b0; nh++;
    @(negedge clk);
    cfg_we = 1'b0; hdr_valid = 1'b0; hc_valid = 1'b0;
    chk(af_drop == 1'b0, "R7 collision uses old table", int'(af_drop), 0);
    send_hdr(1'b0, 2'd2, 32'h09090909, 1'b1, 1'b0, 1'b1, "R7 new entry applies");
    send_hdr(1'b0, 2'd2, 32'h08080808, 1'b1, 1'b0, 1'b0, "R7 new entry matches");

    // R8: disabling port 3's prefix
    cfg_write(1'b0, 2'd3, 4'd0, 1'b0, 32'h64400000, 32'hFFC00000);
    send_hdr(1'b0, 2'd3, 32'h64800000, 1'b1, 1'b0, 1'b0, "R8 port now open");
    send_hdr(1'b1, 2'd1, 32'h64400101, 1'b1, 1'b0, 1'b1, "R8 removed from internal set");

    // R9: out-of-range slot write on port 3 is ignored
    cfg_write(1'b0, 2'd3, 4'd8, 1'b1, 32'h01000000, 32'hFF000000);
    send_hdr(1'b0, 2'd3, 32'h02020202, 1'b1, 1'b0, 1'b0, "R9 slot 8 ignored");

    // R3: a disabled reserved entry no longer blocks
    cfg_write(1'b1, 2'd0, 4'd1, 1'b0, 32'h0A000000, 32'hFF000000);
    send_hdr(1'b0, 2'd3, 32'h0A010203, 1'b1, 1'b0, 1'b0, "R3 reserved slot disabled");

    // R6: address flags ahead of hop-count verdicts
    repeat (4) @(negedge clk);
    begin
      int nd0;
      nd0 = nd;
      send_hdr(1'b0, 2'd0, 32'hCB007101, 1'b0, 1'b0, 1'b0, "R6 early flag a");
      send_hdr(1'b0, 2'd0, 32'h08080808, 1'b0, 1'b0, 1'b1, "R6 early flag b");
      send_hdr(1'b0, 2'd0, 32'hCB007102, 1'b0, 1'b0, 1'b0, "R6 early flag c");
      repeat (4) @(negedge clk);
      chk(nd == nd0, "R6 waits for hop-count", nd, nd0);
    end
    send_hc(1'b1);
    send_hc(1'b0);
    send_hc(1'b0);
    // R6: hop-count verdicts ahead of address flags
    send_hc(1'b0);
    send_hc(1'b1);
    send_hdr(1'b0, 2'd0, 32'h08080808, 1'b0, 1'b0, 1'b1, "R6 late flag a");
    send_hdr(1'b0, 2'd0, 32'hCB007105, 1'b0, 1'b0, 1'b0, "R6 late flag b");
    repeat (6) @(negedge clk);
    chk(nd == na, "R6 all decisions issued", nd, na);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule